// File: doc/BRIEF.md
# Multicycle Microsequencer with Opcode Dispatch

This block is the control unit of a multicycle processor. It does not store a next-state value for every state. A 4-bit microstate register selects one row of a combinational control store. That row drives the datapath strobes and selects for the current cycle. It also supplies a 2-bit sequencing code. The sequencing code steers a four-way next-state select, whose candidates are:

- the fetch state;
- a first opcode-indexed dispatch table, used after decode;
- a second opcode-indexed dispatch table, used after address calculation;
- the current state plus one.

The states, in numeric order, are:

| Code | State | Sequencing | Next state |
|------|-------|------------|------------|
| 0 | FETCH | plus one | DECODE |
| 1 | DECODE | first dispatch | per opcode class |
| 2 | MEM_ADDR | second dispatch | per load or store |
| 3 | MEM_RD | plus one | LOAD_WB |
| 4 | LOAD_WB | to fetch | FETCH |
| 5 | MEM_WR | to fetch | FETCH |
| 6 | R_EXEC | plus one | R_WB |
| 7 | R_WB | to fetch | FETCH |
| 8 | BRANCH | to fetch | FETCH |
| 9 | JUMP | to fetch | FETCH |

The opcode comes from the instruction register. It is only consulted in DECODE and MEM_ADDR. The outputs depend on the current state alone, so they are steady for the whole cycle.

Top module: `microseq_ctrl`

## Requirements
- R1: A synchronous `rst` sampled high puts the state in FETCH (code 0) at that clock edge. FETCH is also the state after reset is released.
- R2: FETCH always advances to DECODE (code 1) at the next edge, whatever the opcode is.
- R3: DECODE chooses the next state from the opcode:
  - opcode 0 goes to R_EXEC (6);
  - opcode 2 goes to JUMP (9);
  - opcode 4 goes to BRANCH (8);
  - opcode 35 or 43 goes to MEM_ADDR (2);
  - any other value goes to FETCH.
- R4: MEM_ADDR chooses the next state from the opcode: 35 goes to MEM_RD (3), 43 goes to MEM_WR (5), and any other value goes to FETCH.
- R5: MEM_RD advances to LOAD_WB, and R_EXEC advances to R_WB. In both cases the next code is the current code plus one, and the opcode is ignored.
- R6: LOAD_WB, MEM_WR, R_WB, BRANCH and JUMP all return to FETCH, and the opcode is ignored.
- R7: The output word is a function of the state alone. Its bit order is {pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr, mem_to_reg, pc_src[1:0], alu_op[1:0], alu_src_b[1:0], alu_src_a, reg_wr, reg_dst}. Only the nonzero fields are listed below; every other field is 0.

| State | Nonzero fields |
|-------|----------------|
| FETCH | pc_wr, mem_rd, ir_wr, alu_src_b=01 |
| DECODE | alu_src_b=11 |
| MEM_ADDR | alu_src_b=10, alu_src_a |
| MEM_RD | iord, mem_rd |
| LOAD_WB | mem_to_reg, reg_wr |
| MEM_WR | iord, mem_wr |
| R_EXEC | alu_op=10, alu_src_a |
| R_WB | reg_wr, reg_dst |
| BRANCH | pc_wr_cond, pc_src=01, alu_op=01, alu_src_a |
| JUMP | pc_wr, pc_src=10 |

- R8: Reset takes priority over every sequencing choice in every state, including the dispatch states.
- R9: `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state register loads on the rising edge |
| rst | input | 1 | Synchronous reset to FETCH |
| op_i | input | 6 | Opcode field from the instruction register |
| pc_wr | output | 1 | Unconditional program-counter write |
| pc_wr_cond | output | 1 | Program-counter write qualified by the branch condition |
| iord | output | 1 | Memory address from the ALU result instead of the PC |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| mem_to_reg | output | 1 | Register write data comes from memory data |
| pc_src | output | 2 | Next-PC source select |
| alu_op | output | 2 | ALU operation class |
| alu_src_b | output | 2 | ALU second operand select |
| alu_src_a | output | 1 | ALU first operand select |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination register field select |

## Verification
Reset and a sequencing decision can land on the same edge. This includes the edges where a dispatch table or the incrementer would have chosen a state other than fetch. The bench provokes this by running every opcode and raising reset after each possible number of cycles into an instruction, which covers every state of every path. It expects FETCH's output word on the following cycle, and it expects DECODE's word on the cycle after that. A long run then changes the opcode every cycle. This confirms that only the two dispatch states ever react to the opcode.

// File: rtl/usq_pkg.sv
package usq_pkg;
    localparam int STATE_W = 4;
    localparam int OP_W    = 6;
    localparam int SEQ_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH    = 4'd0,
        ST_DECODE   = 4'd1,
        ST_MEM_ADDR = 4'd2,
        ST_MEM_RD   = 4'd3,
        ST_LOAD_WB  = 4'd4,
        ST_MEM_WR   = 4'd5,
        ST_R_EXEC   = 4'd6,
        ST_R_WB     = 4'd7,
        ST_BRANCH   = 4'd8,
        ST_JUMP     = 4'd9
    } state_t;

    // Next-state select code: the order is the mux input numbering
    typedef enum logic [SEQ_W-1:0] {
        SEQ_FETCH = 2'd0,
        SEQ_DISP1 = 2'd1,
        SEQ_DISP2 = 2'd2,
        SEQ_NEXT  = 2'd3
    } seq_t;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       iord;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       mem_to_reg;
        logic [1:0] pc_src;
        logic [1:0] alu_op;
        logic [1:0] alu_src_b;
        logic       alu_src_a;
        logic       reg_wr;
        logic       reg_dst;
        seq_t       seq;
    } uword_t;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'd0;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'd2;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'd35;
    localparam logic [OP_W-1:0] OPC_STORE = 6'd43;
endpackage

// File: rtl/usq_ctrl_store.sv
module usq_ctrl_store
    import usq_pkg::*;
(
    input  state_t state_i,
    output uword_t word_o
);
    always_comb begin
        word_o     = '0;
        word_o.seq = SEQ_FETCH;
        unique case (state_i)
            ST_FETCH: begin
                word_o.pc_wr     = 1'b1;
                word_o.mem_rd    = 1'b1;
                word_o.ir_wr     = 1'b1;
                word_o.alu_src_b = 2'b01;
                word_o.seq       = SEQ_NEXT;
            end
            ST_DECODE: begin
                word_o.alu_src_b = 2'b11;
                word_o.seq       = SEQ_DISP1;
            end
            ST_MEM_ADDR: begin
                word_o.alu_src_a = 1'b1;
                word_o.alu_src_b = 2'b10;
                word_o.seq       = SEQ_DISP2;
            end
            ST_MEM_RD: begin
                word_o.iord   = 1'b1;
                word_o.mem_rd = 1'b1;
                word_o.seq    = SEQ_NEXT;
            end
            ST_LOAD_WB: begin
                word_o.mem_to_reg = 1'b1;
                word_o.reg_wr     = 1'b1;
            end
            ST_MEM_WR: begin
                word_o.iord   = 1'b1;
                word_o.mem_wr = 1'b1;
            end
            ST_R_EXEC: begin
                word_o.alu_src_a = 1'b1;
                word_o.alu_op    = 2'b10;
                word_o.seq       = SEQ_NEXT;
            end
            ST_R_WB: begin
                word_o.reg_wr  = 1'b1;
                word_o.reg_dst = 1'b1;
            end
            ST_BRANCH: begin
                word_o.alu_src_a  = 1'b1;
                word_o.alu_op     = 2'b01;
                word_o.pc_wr_cond = 1'b1;
                word_o.pc_src     = 2'b01;
            end
            ST_JUMP: begin
                word_o.pc_wr  = 1'b1;
                word_o.pc_src = 2'b10;
            end
            default: begin
                word_o     = '0;
                word_o.seq = SEQ_FETCH;
            end
        endcase
    end

    always_comb begin
        AST_NO_RDWR_CLASH: assert (!(word_o.mem_rd && word_o.mem_wr)); // R9
    end
endmodule

// File: rtl/usq_dispatch.sv
module usq_dispatch
    import usq_pkg::*;
#(
    parameter int TABLE_ID = 1
) (
    input  logic [OP_W-1:0] op_i,
    output state_t          target_o
);
    generate
        if (TABLE_ID == 1) begin : g_class_table
            always_comb begin
                unique case (op_i)
                    OPC_RTYPE: target_o = ST_R_EXEC;
                    OPC_JUMP:  target_o = ST_JUMP;
                    OPC_BEQ:   target_o = ST_BRANCH;
                    OPC_LOAD,
                    OPC_STORE: target_o = ST_MEM_ADDR;
                    default:   target_o = ST_FETCH;
                endcase
            end
        end else begin : g_mem_table
            always_comb begin
                unique case (op_i)
                    OPC_LOAD:  target_o = ST_MEM_RD;
                    OPC_STORE: target_o = ST_MEM_WR;
                    default:   target_o = ST_FETCH;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/usq_addr_sel.sv
module usq_addr_sel
    import usq_pkg::*;
(
    input  state_t state_i,
    input  seq_t   seq_i,
    input  state_t disp1_i,
    input  state_t disp2_i,
    output state_t next_o
);
    logic [STATE_W-1:0] incr;

    assign incr = state_i + 4'd1;

    always_comb begin
        unique case (seq_i)
            SEQ_FETCH: next_o = ST_FETCH;
            SEQ_DISP1: next_o = disp1_i;
            SEQ_DISP2: next_o = disp2_i;
            SEQ_NEXT:  next_o = state_t'(incr);
            default:   next_o = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/microseq_ctrl.sv
module microseq_ctrl
    import usq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op_i,
    output logic            pc_wr,
    output logic            pc_wr_cond,
    output logic            iord,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            ir_wr,
    output logic            mem_to_reg,
    output logic [1:0]      pc_src,
    output logic [1:0]      alu_op,
    output logic [1:0]      alu_src_b,
    output logic            alu_src_a,
    output logic            reg_wr,
    output logic            reg_dst
);
    state_t state_q;
    state_t state_d;
    state_t disp1;
    state_t disp2;
    uword_t uword;

    usq_ctrl_store u_store (
        .state_i (state_q),
        .word_o  (uword)
    );

    usq_dispatch #(.TABLE_ID(1)) u_disp1 (
        .op_i     (op_i),
        .target_o (disp1)
    );

    usq_dispatch #(.TABLE_ID(2)) u_disp2 (
        .op_i     (op_i),
        .target_o (disp2)
    );

    usq_addr_sel u_sel (
        .state_i (state_q),
        .seq_i   (uword.seq),
        .disp1_i (disp1),
        .disp2_i (disp2),
        .next_o  (state_d)
    );

    // State register process
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    // Output process
    always_comb begin
        pc_wr      = uword.pc_wr;
        pc_wr_cond = uword.pc_wr_cond;
        iord       = uword.iord;
        mem_rd     = uword.mem_rd;
        mem_wr     = uword.mem_wr;
        ir_wr      = uword.ir_wr;
        mem_to_reg = uword.mem_to_reg;
        pc_src     = uword.pc_src;
        alu_op     = uword.alu_op;
        alu_src_b  = uword.alu_src_b;
        alu_src_a  = uword.alu_src_a;
        reg_wr     = uword.reg_wr;
        reg_dst    = uword.reg_dst;
    end

    AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_FETCH |=> state_q == ST_DECODE); // R2
    AST_DECODE_DISPATCH: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_DECODE |=> state_q inside {ST_FETCH, ST_MEM_ADDR, ST_R_EXEC, ST_BRANCH, ST_JUMP}); // R3
    AST_ADDR_DISPATCH: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_MEM_ADDR |=> state_q inside {ST_FETCH, ST_MEM_RD, ST_MEM_WR}); // R4
    AST_READ_THEN_WB: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_MEM_RD |=> state_q == ST_LOAD_WB); // R5
    AST_TERMINAL_RETURN: assert property (@(posedge clk) disable iff (rst)
        state_q inside {ST_LOAD_WB, ST_MEM_WR, ST_R_WB, ST_BRANCH, ST_JUMP} |=> state_q == ST_FETCH); // R6
    AST_STORE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> !mem_rd && iord); // R9
endmodule

// File: tb/microseq_ctrl_tb.sv
module microseq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] op  = 6'd0;
    logic       pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr, mem_to_reg;
    logic [1:0] pc_src, alu_op, alu_src_b;
    logic       alu_src_a, reg_wr, reg_dst;

    int n_run  = 0;
    int n_fail = 0;
    int exp_st = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    microseq_ctrl dut_i (
        .clk(clk), .rst(rst), .op_i(op),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .iord(iord),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
        .mem_to_reg(mem_to_reg), .pc_src(pc_src), .alu_op(alu_op),
        .alu_src_b(alu_src_b), .alu_src_a(alu_src_a),
        .reg_wr(reg_wr), .reg_dst(reg_dst)
    );

    // Expected output word per state (R7 bit order)
    function automatic logic [15:0] exp_word(input int s);
        case (s)
            0: return 16'b1_0_0_1_0_1_0_00_00_01_0_0_0;
            1: return 16'b0_0_0_0_0_0_0_00_00_11_0_0_0;
            2: return 16'b0_0_0_0_0_0_0_00_00_10_1_0_0;
            3: return 16'b0_0_1_1_0_0_0_00_00_00_0_0_0;
            4: return 16'b0_0_0_0_0_0_1_00_00_00_0_1_0;
            5: return 16'b0_0_1_0_1_0_0_00_00_00_0_0_0;
            6: return 16'b0_0_0_0_0_0_0_00_10_00_1_0_0;
            7: return 16'b0_0_0_0_0_0_0_00_00_00_0_1_1;
            8: return 16'b0_1_0_0_0_0_0_01_01_00_1_0_0;
            9: return 16'b1_0_0_0_0_0_0_10_00_00_0_0_0;
            default: return 16'h0;
        endcase
    endfunction

    // Next-state model from R1..R6, R8
    function automatic int exp_next(input int s, input int o, input bit r);
        if (r) return 0;                            // R1 R8
        case (s)
            0: return 1;                            // R2
            1: begin                                // R3
                if (o == 0) return 6;
                if (o == 2) return 9;
                if (o == 4) return 8;
                if (o == 35 || o == 43) return 2;
                return 0;
            end
            2: begin                                // R4
                if (o == 35) return 3;
                if (o == 43) return 5;
                return 0;
            end
            3, 6: return s + 1;                     // R5
            default: return 0;                      // R6
        endcase
    endfunction

    function automatic string req_of(input int prev, input bit r);
        if (r) return "R1/R8";
        case (prev)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3, 6: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Drive inputs at negedge, let one posedge pass, check at the next negedge
    task automatic step(input bit r, input logic [5:0] o);
        logic [15:0] got;
        int prev;
        rst = r;
        op  = o;
        prev = exp_st;
        @(posedge clk);
        @(negedge clk);
        exp_st = exp_next(prev, int'(o), r);
        got = {pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr, mem_to_reg,
               pc_src, alu_op, alu_src_b, alu_src_a, reg_wr, reg_dst};
        n_run++;
        if (got !== exp_word(exp_st)) begin
            n_fail++;
            $display("FAIL %s/R7 state %0d op %0d: word got %b exp %b",
                     req_of(prev, r), exp_st, o, got, exp_word(exp_st));
        end
        if (mem_rd === 1'b1 && mem_wr === 1'b1) begin
            n_fail++;
            $display("FAIL R9: mem_rd %b mem_wr %b exp not both 1", mem_rd, mem_wr);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        @(negedge clk);
        step(1'b1, 6'd0);                           // R1 reset state
        // Sweep every opcode through a full instruction, held constant
        for (int o = 0; o < 64; o++) begin
            step(1'b1, 6'(o));
            for (int c = 0; c < 6; c++) step(1'b0, 6'(o));
        end
        // R8: reset collides with each sequencing decision along every path
        for (int o = 0; o < 64; o++) begin
            for (int d = 1; d <= 5; d++) begin
                step(1'b1, 6'(o));
                for (int c = 0; c < d; c++) step(1'b0, 6'(o));
                step(1'b1, 6'(o));
                step(1'b0, 6'(o));
            end
        end
        // Opcode changes every cycle: only dispatch states react (R2 R5 R6)
        lfsr = 8'hA5;
        step(1'b1, 6'd0);
        for (int c = 0; c < 3000; c++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (lfsr[2:0])
                3'd0: step(1'b0, 6'd35);
                3'd1: step(1'b0, 6'd43);
                3'd2: step(1'b0, 6'd0);
                3'd3: step(1'b0, 6'd4);
                3'd4: step(1'b0, 6'd2);
                default: step(1'b0, lfsr[7:2]);
            endcase
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule